// File: doc/BRIEF.md
# Synchronous Serial Receive Error Handler

This block sits behind the character assembler of a byte-oriented synchronous serial receiver. Each assembled character arrives with a parity-error flag and an end-of-block flag. A level input reports whether the carrier is still present. The block stores accepted characters in a small FIFO that a downstream consumer drains over a valid/ready stream. While storing them, the block watches for four conditions: carrier loss, FIFO overrun, parity errors, and the CRC result at the end of a block. When a block ends, normally or on an error, the block reports the closing status in a one-cycle pulse. It can also raise a receive interrupt, and it can return the receiver to hunt mode until the external sync detector finds the next sync pattern.

The receive side carries no ready signal, because a serial line cannot be stalled. When the FIFO is full and nothing is popped in the same cycle, the incoming character replaces the most recently stored entry. That replaced entry and its parity flag are lost. On the output side, out_valid stays high while entries remain, and an entry is consumed on every cycle where out_valid and out_ready are both high. While out_ready is low, the head entry does not move.

A running CRC-16 (polynomial 0x8005, fed MSB first, initial value zero, restarted by each sync detection) covers the characters of the block. The visible CRC status lags the data by one character. A saturating counter keeps the number of parity errors.

Top module: `rx_err_handler`

## Requirements
- R1: After reset the block is in hunt mode (hunt=1), close_vld=0, irq=0, out_valid=0 and par_count=0.
- R2: In hunt mode, characters are neither stored nor reported. A sync_det pulse moves the block to receive mode at the next clock edge and restarts the CRC at zero.
- R3: In receive mode, characters that are accepted without error are delivered on out_data in arrival order, with out_par=0. out_valid stays high and the head entry is held while out_ready is low.
- R4: A character that arrives while the FIFO holds DEPTH entries, with no pop in that cycle, replaces the last stored entry, and the new entry takes the new character's parity flag. The block closes with close_stat=4'b0100 (overrun) and enters hunt mode.
- R5: In receive mode, cd_ok=0 closes the block at once with close_stat=4'b1000 and enters hunt mode. Any character presented in that cycle is dropped and is not checked for other errors.
- R6: A character with rx_par_err=1 is stored with out_par=1. The block closes with close_stat=4'b0010, increments par_count and enters hunt mode.
- R7: When several conditions occur in the same cycle, only the highest one is recorded: carrier loss first, then overrun, then parity. par_count changes only when parity is the recorded condition.
- R8: par_count saturates at 2^CNT_W-1.
- R9: After each stored character, crc_run_bad is 1 exactly when the CRC over all earlier characters of the block is non-zero. This means the status lags the data by one character.
- R10: A character flagged rx_eob is stored, and one clock later the block closes. close_stat is 4'b0000 when the CRC over the whole block, including that character, is zero, and 4'b0001 when it is not. The block then enters hunt mode.
- R11: irq pulses in the same cycle as close_vld when irq_en was high at that closing edge, and is low at every other time.
- R12: close_vld is a single-cycle pulse. While it is high, at most one close_stat bit is set (bit 3 carrier loss, bit 2 overrun, bit 1 parity, bit 0 CRC bad), and hunt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error on this character |
| rx_eob | input | 1 | Character is the end-of-block control character |
| cd_ok | input | 1 | Carrier present (level) |
| sync_det | input | 1 | Sync pattern found; leave hunt mode |
| irq_en | input | 1 | Receive interrupt enable |
| out_valid | output | 1 | FIFO head entry is valid |
| out_ready | input | 1 | Consumer takes the head entry |
| out_data | output | 8 | FIFO head character |
| out_par | output | 1 | Parity flag of the head entry |
| hunt | output | 1 | Receiver is in hunt mode |
| crc_run_bad | output | 1 | Lagging running-CRC status |
| close_vld | output | 1 | Buffer close pulse |
| close_stat | output | 4 | Close status: carrier lost, overrun, parity, CRC bad |
| irq | output | 1 | Receive interrupt pulse |
| par_count | output | CNT_W | Saturating parity error count |

## Verification
A stuck or wrong receive state shows up within one character. Characters sent in hunt mode would reach out_valid, or a close would fail to set hunt. A corrupted CRC accumulator or a mishandled hold register shows on crc_run_bad after the very next character, well before the end-of-block status. A slip in FIFO pointers becomes visible the next time the consumer drains: the overwritten slot or the order of entries is wrong. A wrong priority shows in the same closing pulse as an extra status bit or an unexpected change of par_count.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

  typedef enum logic [1:0] {ST_HUNT, ST_RECV, ST_FLUSH} rx_state_e;

  typedef struct packed {
    logic carrier_lost;
    logic overrun;
    logic parity;
    logic crc_bad;
  } close_stat_t;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] acc,
                                                input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] r;
    logic fb;
    r = acc;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ din[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxe_fifo.sv
module rxe_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         ovw,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, prev_ptr;
  logic [AW:0] cnt;
  logic do_pop;

  assign do_pop   = pop && !empty;
  assign prev_ptr = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
  assign full     = (cnt == FULL_CNT);
  assign empty    = (cnt == '0);
  assign rdata    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
    else if (ovw) mem[prev_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      if (push && !do_pop) cnt <= cnt + 1'b1;
      else if (!push && do_pop) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rxe_crc.sv
module rxe_crc
  import rxe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fold,
  input  logic [BYTE_W-1:0] din,
  output logic              lag_bad,
  output logic              final_bad
);
  logic [CRC_W-1:0] acc;
  logic [BYTE_W-1:0] held;
  logic held_vld;
  logic [CRC_W-1:0] final_crc;

  assign final_crc = held_vld ? crc_step(acc, held) : acc;
  assign lag_bad   = (acc != '0);
  assign final_bad = (final_crc != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc      <= '0;
      held     <= '0;
      held_vld <= 1'b0;
    end else if (fold) begin
      if (held_vld) acc <= crc_step(acc, held);
      held     <= din;
      held_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/rxe_satcnt.sv
module rxe_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (inc && (count != '1)) count <= count + 1'b1;
  end
endmodule

// File: rtl/rx_err_handler.sv
module rx_err_handler
  import rxe_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_eob,
  input  logic              cd_ok,
  input  logic              sync_det,
  input  logic              irq_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_par,
  output logic              hunt,
  output logic              crc_run_bad,
  output logic              close_vld,
  output logic [3:0]        close_stat,
  output logic              irq,
  output logic [CNT_W-1:0]  par_count
);
  localparam int ENTRY_W = BYTE_W + 1;

  rx_state_e state, state_nxt;
  logic push, ovw, fold, clr, cls, par_inc, pop, full, empty, crc_final_bad;
  close_stat_t stat;
  logic [ENTRY_W-1:0] rd_entry;

  assign pop       = out_valid && out_ready;
  assign out_valid = !empty;
  assign out_data  = rd_entry[BYTE_W-1:0];
  assign out_par   = rd_entry[BYTE_W];
  assign hunt      = (state == ST_HUNT);

  always_comb begin
    state_nxt = state;
    push      = 1'b0;
    ovw       = 1'b0;
    fold      = 1'b0;
    clr       = 1'b0;
    cls       = 1'b0;
    par_inc   = 1'b0;
    stat      = '0;
    unique case (state)
      ST_HUNT: begin
        if (sync_det) begin
          state_nxt = ST_RECV;
          clr       = 1'b1;
        end
      end
      ST_RECV: begin
        if (!cd_ok) begin
          cls               = 1'b1;
          stat.carrier_lost = 1'b1;
          state_nxt         = ST_HUNT;
        end else if (rx_valid) begin
          if (full && !pop) begin
            ovw          = 1'b1;
            cls          = 1'b1;
            stat.overrun = 1'b1;
            state_nxt    = ST_HUNT;
          end else if (rx_par_err) begin
            push        = 1'b1;
            cls         = 1'b1;
            stat.parity = 1'b1;
            par_inc     = 1'b1;
            state_nxt   = ST_HUNT;
          end else begin
            push = 1'b1;
            fold = 1'b1;
            if (rx_eob) state_nxt = ST_FLUSH;
          end
        end
      end
      ST_FLUSH: begin
        cls          = 1'b1;
        stat.crc_bad = crc_final_bad;
        state_nxt    = ST_HUNT;
      end
      default: state_nxt = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      close_vld  <= 1'b0;
      close_stat <= '0;
      irq        <= 1'b0;
    end else begin
      state      <= state_nxt;
      close_vld  <= cls;
      close_stat <= stat;
      irq        <= cls && irq_en;
    end
  end

  rxe_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .ovw(ovw),
    .wdata({rx_par_err, rx_data}), .pop(pop), .rdata(rd_entry),
    .full(full), .empty(empty)
  );

  rxe_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fold(fold), .din(rx_data),
    .lag_bad(crc_run_bad), .final_bad(crc_final_bad)
  );

  rxe_satcnt #(.W(CNT_W)) u_pcnt (
    .clk(clk), .rst_n(rst_n), .inc(par_inc), .count(par_count)
  );
endmodule

// File: rtl/rx_err_handler_chk.sv
module rx_err_handler_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic             hunt,
  input logic             close_vld,
  input logic [3:0]       close_stat,
  input logic             irq,
  input logic [CNT_W-1:0] par_count
);
  // R12
  stat_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_vld |-> $onehot0(close_stat));

  // R12
  close_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_vld |=> !close_vld);

  // R12
  close_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_vld |-> hunt);

  // R11
  irq_only_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> close_vld);

  // R11
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_vld |-> (irq == $past(irq_en)));

  // R2
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt |=> !close_vld);

  // R6
  par_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_count != $past(par_count)) |->
      (close_vld && close_stat == 4'b0010 && par_count == $past(par_count) + CNT_W'(1)));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

bind rx_err_handler rx_err_handler_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .out_valid(out_valid),
  .out_ready(out_ready), .hunt(hunt), .close_vld(close_vld),
  .close_stat(close_stat), .irq(irq), .par_count(par_count)
);

// File: tb/rx_err_handler_tb.sv
module rx_err_handler_tb;
  localparam int DEPTH = 4;
  localparam int CNT_W = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_par_err = 0, rx_eob = 0, cd_ok = 1, sync_det = 0, irq_en = 1;
  logic out_ready = 1;
  logic [7:0] rx_data = '0;
  logic out_valid, out_par, hunt, crc_run_bad, close_vld, irq;
  logic [7:0] out_data;
  logic [3:0] close_stat;
  logic [CNT_W-1:0] par_count;

  int nchk = 0, nfail = 0, pc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_err_handler #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_eob(rx_eob), .cd_ok(cd_ok), .sync_det(sync_det),
    .irq_en(irq_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_par(out_par), .hunt(hunt), .crc_run_bad(crc_run_bad),
    .close_vld(close_vld), .close_stat(close_stat), .irq(irq), .par_count(par_count)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic msb = r[15] ^ d[7-k];
      r = r << 1;
      if (msb) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  function automatic int sat_inc(input int v);
    return (v >= CNT_MAX) ? CNT_MAX : v + 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic p, input logic e);
    rx_valid = 1; rx_data = d; rx_par_err = p; rx_eob = e;
    step();
    rx_valid = 0; rx_par_err = 0; rx_eob = 0;
  endtask

  task automatic do_sync();
    sync_det = 1;
    step();
    sync_det = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] blk [8];
    logic [15:0] c, lag;
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1", "hunt", hunt, 1);
    chk("R1", "close_vld", close_vld, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "par_count", par_count, 0);
    chk("R1", "irq", irq, 0);

    // R2 characters ignored in hunt
    send(8'hAA, 1, 1);
    chk("R2", "out_valid in hunt", out_valid, 0);
    chk("R2", "close in hunt", close_vld, 0);
    chk("R2", "par_count in hunt", par_count, 0);
    step();
    chk("R2", "no late close", close_vld, 0);
    do_sync();
    chk("R2", "hunt after sync", hunt, 0);

    // R3 R9 R10 good block, directed
    blk[0] = 8'h31; blk[1] = 8'h32; blk[2] = 8'h33;
    c = 0;
    for (int i = 0; i < 3; i++) c = ref_crc(c, blk[i]);
    blk[3] = c[15:8]; blk[4] = c[7:0];
    lag = 0;
    for (int i = 0; i < 5; i++) begin
      send(blk[i], 0, i == 4);
      chk("R3", "out_data", out_data, blk[i]);
      chk("R3", "out_par", out_par, 0);
      chk("R9", "crc lag", crc_run_bad, lag != 0);
      lag = ref_crc(lag, blk[i]);
    end
    chk("R10", "close not yet", close_vld, 0);
    step();
    chk("R10", "close good", close_vld, 1);
    chk("R10", "stat good", close_stat, 4'b0000);
    chk("R11", "irq enabled", irq, 1);
    chk("R10", "hunt after eob", hunt, 1);
    step();
    chk("R12", "close one pulse", close_vld, 0);
    chk("R11", "irq low", irq, 0);

    // R10 R11 bad CRC, interrupt masked
    irq_en = 0;
    do_sync();
    send(8'h01, 0, 0);
    send(8'h02, 0, 1);
    step();
    chk("R10", "stat bad crc", close_stat, 4'b0001);
    chk("R11", "irq masked", irq, 0);
    irq_en = 1;

    // R6 parity
    do_sync();
    send(8'h5C, 1, 0);
    pc = sat_inc(pc);
    chk("R6", "stat parity", close_stat, 4'b0010);
    chk("R6", "par_count", par_count, pc);
    chk("R6", "stored char", out_data, 8'h5C);
    chk("R6", "stored flag", out_par, 1);
    chk("R6", "hunt", hunt, 1);
    step();

    // R5 R7 carrier loss beats parity
    do_sync();
    send(8'h55, 0, 0);
    cd_ok = 0;
    send(8'h66, 1, 0);
    cd_ok = 1;
    chk("R5", "stat cd", close_stat, 4'b1000);
    chk("R7", "no parity count", par_count, pc);
    chk("R5", "char dropped", out_valid, 0);
    chk("R5", "hunt", hunt, 1);

    // R4 R7 overrun with parity on the overwriting char
    out_ready = 0;
    do_sync();
    for (int i = 0; i < DEPTH; i++) send(8'h10 + 8'(i), 0, 0);
    send(8'h99, 1, 0);
    chk("R4", "stat overrun", close_stat, 4'b0100);
    chk("R7", "overrun over parity count", par_count, pc);
    chk("R4", "hunt", hunt, 1);
    step();
    chk("R3", "held while not ready", out_data, 8'h10);
    out_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R4", "drain valid", out_valid, 1);
      chk("R4", "drain data", out_data, (i == DEPTH - 1) ? 8'h99 : 8'h10 + 8'(i));
      chk("R4", "drain flag", out_par, i == DEPTH - 1);
      step();
    end
    chk("R4", "drained", out_valid, 0);

    // R8 saturation
    for (int n = 0; n < CNT_MAX + 3; n++) begin
      do_sync();
      send(8'(n), 1, 0);
      pc = sat_inc(pc);
      chk("R8", "par_count", par_count, pc);
    end

    // random blocks
    for (int b = 0; b < 40; b++) begin
      int n, mode, p;
      n = 1 + int'($urandom % 4);
      mode = int'($urandom % 3);
      p = int'($urandom % n);
      irq_en = $urandom % 2;
      c = 0;
      for (int i = 0; i < n; i++) begin
        blk[i] = 8'($urandom);
        c = ref_crc(c, blk[i]);
      end
      blk[n] = c[15:8]; blk[n+1] = c[7:0];
      if (mode == 1) blk[n+1] = blk[n+1] ^ (8'd1 << ($urandom % 8));
      do_sync();
      lag = 0;
      if (mode == 2) begin
        for (int i = 0; i <= p; i++) send(blk[i], i == p, 0);
        pc = sat_inc(pc);
        chk("R6", "rand parity stat", close_stat, 4'b0010);
        chk("R8", "rand par_count", par_count, pc);
        chk("R11", "rand irq", irq, irq_en);
      end else begin
        for (int i = 0; i < n + 2; i++) begin
          send(blk[i], 0, i == n + 1);
          chk("R9", "rand crc lag", crc_run_bad, lag != 0);
          lag = ref_crc(lag, blk[i]);
        end
        chk("R10", "rand no early close", close_vld, 0);
        step();
        chk("R10", "rand close stat", close_stat, (mode == 1) ? 4'b0001 : 4'b0000);
        chk("R11", "rand irq", irq, irq_en);
      end
      step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule